// File: doc/BRIEF.md
# Post-Trigger Sample Count Stop Controller

This block sits between a conversion pacer and an A/D converter and decides which conversion-trigger pulses reach the converter. While capture mode is enabled, triggers flow through without limit. The first rising edge of an external event input arms a down-counter. Each later trigger decrements that counter, and once it reaches zero the trigger path closes by itself. The result is a capture window that holds an unbounded stream of samples before the event and exactly N samples after it.

Software loads N while the mode is off and then enables the mode. It polls the live count and a sticky stopped flag to see when acquisition has ended. Turning the mode off clears the flag, reloads N and opens the trigger path again. Turning the mode back on waits for the next event. The event input can be synchronised through a configurable flop chain, or taken directly when it is already in the clock domain.

Top module: `posttrig_stop_ctrl`

## Requirements
- R1: After reset, `trig_out` is 0, `stopped` is 0 and `cnt_value` is 1.
- R2: While `stopped` is 0 and the mode is off, a pulse on `trig_in` appears on `trig_out` exactly one clock later.
- R3: With the mode on and no event edge seen yet, every trigger is passed and `cnt_value` keeps the loaded N.
- R4: After the event edge, each trigger decrements `cnt_value` by one, and exactly N triggers are passed to `trig_out`.
- R5: When the count reaches zero, `stopped` goes to 1 and stays there while the mode is on. Later triggers are blocked.
- R6: A load of 0 is stored as 1, so one sample follows the event and the counter never wraps below zero.
- R7: A trigger in the same cycle as the detected event edge counts as the first post-event sample.
- R8: Only the first event rising edge after arming is honoured. Later edges, and a level already high when the mode is turned on, do not restart or start the count.
- R9: A count write (`cnt_wr`) while `mode_en` is 1 is ignored. `cnt_value` is unchanged.
- R10: Turning the mode off clears `stopped` and reloads `cnt_value` with N. Turning it back on re-arms for a new capture of N samples.
- R11: With the default 2-stage synchroniser, an event edge driven before clock edge k is detected in the cycle between edges k+1 and k+2. A trigger sampled at edge k+2 is therefore the coincident one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Capture mode enable |
| cnt_wr | input | 1 | Write strobe for the post-event sample count |
| cnt_wdata | input | 16 | Post-event sample count N |
| evt_in | input | 1 | External event, may be asynchronous |
| trig_in | input | 1 | Conversion trigger pulses from the pacer |
| trig_out | output | 1 | Gated, registered trigger to the converter |
| stopped | output | 1 | Sticky flag: post-event count exhausted |
| cnt_value | output | 16 | Live count value |

## Verification
The detected event edge and a conversion trigger can land in the same cycle. In that cycle the arming transition and the first decrement must both take effect. The bench provokes this by placing a trigger exactly two clock edges after driving the event, which is where the two-stage synchroniser produces its edge. It judges the result by the live count dropping from N to N-1 at once, and by exactly N triggers passing in total. A second overlap, a count write while the mode is on, is judged by the live count staying unchanged.

// File: rtl/posttrig_pkg.sv
package posttrig_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_COUNT = 2'd2,
      ST_STOP  = 2'd3
   } pt_state_e;
endpackage

// File: rtl/pt_event_sync.sv
module pt_event_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_raw,
   output logic evt_edge
);
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_stages
      $error("pt_event_sync: SYNC_STAGES must be 0..4");
   end

   logic evt_s;
   logic evt_prev;

   if (SYNC_STAGES == 0) begin : g_direct
      assign evt_s = evt_raw;
   end else begin : g_chain
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[SYNC_STAGES-2+1-1:0], evt_raw};
      end
      assign evt_s = chain_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_prev <= 1'b0;
      else        evt_prev <= evt_s;
   end

   assign evt_edge = evt_s & ~evt_prev;

   // R11: a detected edge lasts exactly one cycle
   p_edge_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      evt_edge |=> !evt_edge);
endmodule

// File: rtl/pt_down_counter.sv
module pt_down_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             reload_en,
   input  logic             dec_en,
   output logic [CNT_W-1:0] cnt_q,
   output logic             cnt_last
);
   if (CNT_W < 2) begin : g_bad_width
      $error("pt_down_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] n_q;
   logic [CNT_W-1:0] wr_sat;

   assign wr_sat = (wr_data == '0) ? ONE : wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     n_q <= ONE;
      else if (wr_en) n_q <= wr_sat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= ONE;
      else if (wr_en)     cnt_q <= wr_sat;
      else if (reload_en) cnt_q <= n_q;
      else if (dec_en)    cnt_q <= cnt_q - ONE;
   end

   assign cnt_last = (cnt_q == ONE);

   // R6: never decrement from zero
   p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dec_en |-> cnt_q != '0);
   // R4: each decrement removes exactly one
   p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dec_en && !wr_en && !reload_en |=> cnt_q == $past(cnt_q) - ONE);
   // R9: without a write, reload or decrement the count holds
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en && !reload_en && !dec_en |=> $stable(cnt_q));
endmodule

// File: rtl/pt_trig_gate.sv
module pt_trig_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   input  logic gate_en,
   output logic trig_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_out <= 1'b0;
      else        trig_out <= trig_in & gate_en;
   end

   // R2: one cycle of latency through an open gate
   p_gate_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trig_in && gate_en |=> trig_out);
   p_gate_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_in |=> !trig_out);
endmodule

// File: rtl/posttrig_stop_ctrl.sv
module posttrig_stop_ctrl #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_en,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             evt_in,
   input  logic             trig_in,
   output logic             trig_out,
   output logic             stopped,
   output logic [CNT_W-1:0] cnt_value
);
   import posttrig_pkg::*;

   pt_state_e state_q, state_d;
   logic      evt_edge;
   logic      cnt_last;
   logic      wr_en, reload_en, dec_en, gate_en, hit;

   pt_event_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_raw  (evt_in),
      .evt_edge (evt_edge)
   );

   assign hit       = (state_q == ST_COUNT) || (state_q == ST_ARMED && evt_edge);
   assign dec_en    = mode_en && trig_in && hit;
   assign wr_en     = cnt_wr && !mode_en;
   assign reload_en = (state_q == ST_IDLE);
   assign gate_en   = (state_q != ST_STOP);

   pt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (cnt_wdata),
      .reload_en (reload_en),
      .dec_en    (dec_en),
      .cnt_q     (cnt_value),
      .cnt_last  (cnt_last)
   );

   always_comb begin
      state_d = state_q;
      if (!mode_en) begin
         state_d = ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE:  state_d = ST_ARMED;
            ST_ARMED: if (evt_edge) state_d = (trig_in && cnt_last) ? ST_STOP : ST_COUNT;
            ST_COUNT: if (trig_in && cnt_last) state_d = ST_STOP;
            ST_STOP:  state_d = ST_STOP;
            default:  state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   pt_trig_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_in  (trig_in),
      .gate_en  (gate_en),
      .trig_out (trig_out)
   );

   assign stopped = (state_q == ST_STOP);

   // R5: stopped blocks triggers
   p_stop_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stopped && trig_in |=> !trig_out);
   // R5: stopped is sticky while mode is on
   p_stop_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stopped && mode_en |=> stopped);
   // R10: turning the mode off clears stopped
   p_stop_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_en |=> !stopped);
   // R2: with the mode off and not stopped, triggers pass
   p_off_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_en && !stopped && trig_in |=> trig_out);
   // R9: writes while mode is on leave the count alone outside counting
   p_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_en && cnt_wr && state_q == ST_STOP |=> $stable(cnt_value));
endmodule

// File: tb/posttrig_stop_ctrl_tb.sv
`timescale 1ns/1ps
module posttrig_stop_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_en = 1'b0;
   logic        cnt_wr = 1'b0;
   logic [15:0] cnt_wdata = '0;
   logic        evt_in = 1'b0;
   logic        trig_in = 1'b0;
   logic        trig_out;
   logic        stopped;
   logic [15:0] cnt_value;

   int checks = 0;
   int failures = 0;
   int passed = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   posttrig_stop_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .cnt_wr(cnt_wr),
      .cnt_wdata(cnt_wdata), .evt_in(evt_in), .trig_in(trig_in),
      .trig_out(trig_out), .stopped(stopped), .cnt_value(cnt_value)
   );

   always @(negedge clk) if (rst_n && trig_out) passed++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_trig();
      @(negedge clk) trig_in = 1'b1;
      @(negedge clk) trig_in = 1'b0;
   endtask

   task automatic load_n(input logic [15:0] n);
      @(negedge clk) begin cnt_wr = 1'b1; cnt_wdata = n; end
      @(negedge clk) cnt_wr = 1'b0;
   endtask

   task automatic raise_evt();
      @(negedge clk) evt_in = 1'b1;
      idle(4);
   endtask

   task automatic drop_evt();
      @(negedge clk) evt_in = 1'b0;
      idle(4);
   endtask

   task automatic test_reset();
      chk("R1 trig_out", trig_out, 0);
      chk("R1 stopped", stopped, 0);
      chk("R1 cnt_value", cnt_value, 1);
   endtask

   task automatic test_passthrough();
      @(negedge clk) trig_in = 1'b1;
      @(negedge clk) begin trig_in = 1'b0; chk("R2 latency one", trig_out, 1); end
      @(negedge clk) chk("R2 single pulse", trig_out, 0);
   endtask

   task automatic test_capture();
      int base;
      load_n(16'd3);
      idle(1);
      chk("R3 loaded N", cnt_value, 3);
      @(negedge clk) mode_en = 1'b1;
      idle(1);
      base = passed;
      for (int i = 0; i < 5; i++) pulse_trig();
      idle(1);
      chk("R3 free run passed", passed - base, 5);
      chk("R3 count held", cnt_value, 3);
      raise_evt();
      base = passed;
      pulse_trig();
      idle(1);
      chk("R4 first decrement", cnt_value, 2);
      for (int i = 0; i < 4; i++) pulse_trig();
      idle(1);
      chk("R4 exactly N passed", passed - base, 3);
      chk("R5 stopped set", stopped, 1);
      chk("R5 count zero", cnt_value, 0);
      drop_evt();
      raise_evt();
      base = passed;
      pulse_trig();
      idle(1);
      chk("R8 late edge ignored stopped", stopped, 1);
      chk("R5 blocked after stop", passed - base, 0);
   endtask

   task automatic test_wr_and_rearm();
      int base;
      load_n(16'd7);
      idle(1);
      chk("R9 write while on ignored", cnt_value, 0);
      drop_evt();
      @(negedge clk) mode_en = 1'b0;
      idle(2);
      chk("R10 stopped cleared", stopped, 0);
      chk("R10 reload N", cnt_value, 3);
      @(negedge clk) mode_en = 1'b1;
      idle(1);
      raise_evt();
      base = passed;
      pulse_trig();
      drop_evt();
      raise_evt();
      idle(1);
      chk("R8 second edge no restart", cnt_value, 2);
      for (int i = 0; i < 4; i++) pulse_trig();
      idle(1);
      chk("R10 re-armed capture N", passed - base, 3);
      drop_evt();
      @(negedge clk) mode_en = 1'b0;
      idle(2);
   endtask

   task automatic test_zero_load();
      int base;
      load_n(16'd0);
      idle(1);
      chk("R6 zero stored as one", cnt_value, 1);
      @(negedge clk) mode_en = 1'b1;
      idle(1);
      raise_evt();
      base = passed;
      for (int i = 0; i < 3; i++) pulse_trig();
      idle(1);
      chk("R6 one sample after event", passed - base, 1);
      chk("R6 stopped", stopped, 1);
      drop_evt();
      @(negedge clk) mode_en = 1'b0;
      idle(2);
   endtask

   task automatic test_coincident();
      int base;
      load_n(16'd2);
      @(negedge clk) mode_en = 1'b1;
      idle(2);
      chk("R7 count before event", cnt_value, 2);
      base = passed;
      @(negedge clk) evt_in = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk) trig_in = 1'b1;
      @(negedge clk) trig_in = 1'b0;
      chk("R11 coincident decrement", cnt_value, 1);
      chk("R7 coincident passed", trig_out, 1);
      for (int i = 0; i < 3; i++) pulse_trig();
      idle(1);
      chk("R7 total N passed", passed - base, 2);
      @(negedge clk) mode_en = 1'b0;
      idle(2);
   endtask

   task automatic test_level_at_arm();
      int base;
      @(negedge clk) mode_en = 1'b1;
      idle(3);
      base = passed;
      for (int i = 0; i < 4; i++) pulse_trig();
      idle(1);
      chk("R8 held level no start passed", passed - base, 4);
      chk("R8 held level count", cnt_value, 2);
      chk("R8 held level not stopped", stopped, 0);
      @(negedge clk) begin mode_en = 1'b0; evt_in = 1'b0; end
      idle(2);
   endtask

   initial begin
      idle(3);
      @(negedge clk) rst_n = 1'b1;
      idle(1);
      test_reset();
      test_passthrough();
      test_capture();
      test_wr_and_rearm();
      test_zero_load();
      test_coincident();
      test_level_at_arm();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule